// File: doc/BRIEF.md
# Write-Protected Presence-Detect Serial EEPROM

This block models a 256-byte serial EEPROM that answers as a slave on a two-wire I2C bus. A host uses it to hold module description data. The host sets an internal byte pointer with a word-address byte. It can then read one byte or stream many bytes. It can also write one byte or a short burst that stays inside a 16-byte page. The block runs on a system clock that is much faster than SCL. It samples SCL and SDA on that clock, and it changes SDA only while SCL is low.

The block applies write permission by address. The lower 128 bytes are fixed at manufacture, and no bus write can change them. The upper 128 bytes accept writes only while the write-protect input is low. Tying that input low leaves the upper half writable. The contents are loaded through a preload port, which takes priority over the bus. After a stop that ends a write, the block stays busy for a fixed number of clock cycles. During that time it does not acknowledge its own address.

Top module: `spd_eeprom`

## Requirements
- R1: After reset the block releases SDA (`sda_oe` = 0) and waits for a start condition.
- R2: The block acknowledges (drives SDA low in the 9th clock) an address byte whose upper 7 bits equal `DEV_ADDR`, where bit 0 is the direction (1 = read). It also acknowledges the word-address byte that follows a write-direction address. It never acknowledges any other device address.
- R3: A word-address write followed by a repeated start and a read-direction address returns the byte at that word address, sent MSB first.
- R4: During a read, each master ACK makes the block send the next byte, and the pointer wraps from 255 to 0. A master NACK ends the transfer, and SDA stays released.
- R5: Bytes 0 to 127 (address bit 7 = 0) never change on a bus write, but their data bytes are still acknowledged.
- R6: Bytes 128 to 255 (address bit 7 = 1) take the written data while `wp_i` is low.
- R7: While `wp_i` is high, writes to bytes 128 to 255 are acknowledged and discarded.
- R8: During a write burst the pointer increments only in its low 4 bits, so the burst wraps inside its 16-byte page.
- R9: A stop that ends a write containing at least one data byte makes the block refuse its address for `BUSY_CYCLES` clock cycles. After that it acknowledges again.
- R10: A clock cycle with `pre_en_i` high stores `pre_data_i` at `pre_addr_i`, whatever the state of the bus.
- R11: The block changes `sda_oe` and `sda_o` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| sda_o | output | 1 | Data value the slave drives |
| sda_oe | output | 1 | High while the slave drives SDA |
| wp_i | input | 1 | Write protect for the upper half; high blocks writes |
| pre_en_i | input | 1 | Preload write strobe |
| pre_addr_i | input | 8 | Preload byte address |
| pre_data_i | input | 8 | Preload byte value |

## Verification
First, a known pattern is loaded through the preload port. The bench then reads it back with single random reads and with sequential reads that cross address 255. This separates the pointer load from the increment-and-wrap path. Write bursts are aimed at the locked lower half, at the upper half with protection off, and at the upper half with protection on. Each burst is acknowledged in the same way, so only the later read-back shows whether the permission rule was applied. A burst that starts two bytes below a page end shows the page wrap. Address bytes with a wrong device address, and address bytes sent right after a write, are both refused. Once the busy window has passed, the same address is acknowledged again.

// File: rtl/spd_eeprom_pkg.sv
package spd_eeprom_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,     // ignore bus until start
        ST_RX,       // shifting in a byte from the master
        ST_ACK_ARM,  // byte taken, drive ACK at next SCL fall
        ST_ACK,      // ACK on the wire, act at next SCL fall
        ST_TX,       // shifting out a byte to the master
        ST_MACK,     // released, sample master ACK on SCL rise
        ST_TX_NEXT   // master acked, load next byte at SCL fall
    } ee_state_e;

    typedef enum logic [1:0] {
        PH_DEVICE,
        PH_WORD,
        PH_DATA
    } ee_phase_e;

endpackage

// File: rtl/spd_eeprom_sync.sv
module spd_eeprom_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop,
    output logic sda_s
);
    logic [1:0] scl_d, scl_q;
    logic [1:0] sda_d, sda_q;

    always_comb begin
        scl_d = {scl_q[0], scl_i};
        sda_d = {sda_q[0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 2'b11;
            sda_q <= 2'b11;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end

    // index 0 is the newest sample, index 1 the one before
    assign scl_rise  = scl_q[0] & ~scl_q[1];
    assign scl_fall  = ~scl_q[0] & scl_q[1];
    assign bus_start = scl_q[0] & scl_q[1] & ~sda_q[0] & sda_q[1];
    assign bus_stop  = scl_q[0] & scl_q[1] & sda_q[0] & ~sda_q[1];
    assign sda_s     = sda_q[0];
endmodule

// File: rtl/spd_eeprom_array.sv
module spd_eeprom_array #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/spd_eeprom.sv
module spd_eeprom #(
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         ADDR_W      = 8,
    parameter int         PAGE_W      = 4,
    parameter int         BUSY_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_o,
    output logic              sda_oe,
    input  logic              wp_i,
    input  logic              pre_en_i,
    input  logic [ADDR_W-1:0] pre_addr_i,
    input  logic [7:0]        pre_data_i
);
    import spd_eeprom_pkg::*;

    localparam int BW = $clog2(BUSY_CYCLES + 1);
    localparam logic [BW-1:0]     BUSY_LOAD = BW'(BUSY_CYCLES);
    localparam logic [BW-1:0]     BUSY_ONE  = BW'(1);
    localparam logic [ADDR_W-1:0] PTR_ONE   = ADDR_W'(1);
    localparam logic [PAGE_W-1:0] PAGE_ONE  = PAGE_W'(1);

    typedef struct packed {
        ee_state_e         st;
        ee_phase_e         ph;
        logic [2:0]        cnt;
        logic [7:0]        sh;
        logic [ADDR_W-1:0] ptr;
        logic              rd;
        logic              oe;
        logic              o;
        logic              wrote;
        logic [BW-1:0]     busy;
    } ee_regs_t;

    ee_regs_t state_d, state_q;

    logic scl_rise, scl_fall, bus_start, bus_stop, sda_s;
    logic [7:0]        rdata;
    logic [7:0]        byte_in;
    logic              bus_we;
    logic              arr_we;
    logic [ADDR_W-1:0] arr_waddr;
    logic [7:0]        arr_wdata;
    logic [ADDR_W-1:0] ptr_q;
    logic [PAGE_W-1:0] page_nx;

    spd_eeprom_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .sda_s     (sda_s)
    );

    // preload owns the write port whenever it is active
    assign arr_we    = pre_en_i | bus_we;
    assign arr_waddr = pre_en_i ? pre_addr_i : state_q.ptr;
    assign arr_wdata = pre_en_i ? pre_data_i : byte_in;
    assign ptr_q     = state_q.ptr;

    spd_eeprom_array #(.AW(ADDR_W)) u_array (
        .clk   (clk),
        .we    (arr_we),
        .waddr (arr_waddr),
        .wdata (arr_wdata),
        .raddr (state_q.ptr),
        .rdata (rdata)
    );

    always_comb begin
        state_d = state_q;
        bus_we  = 1'b0;
        byte_in = {state_q.sh[6:0], sda_s};
        page_nx = state_q.ptr[PAGE_W-1:0] + PAGE_ONE;

        if (state_q.busy != '0) state_d.busy = state_q.busy - BUSY_ONE;

        if (bus_start) begin
            state_d.st  = ST_RX;
            state_d.ph  = PH_DEVICE;
            state_d.cnt = 3'd0;
            state_d.oe  = 1'b0;
        end else if (bus_stop) begin
            state_d.st = ST_IDLE;
            state_d.oe = 1'b0;
            if (state_q.wrote) begin
                state_d.busy  = BUSY_LOAD;
                state_d.wrote = 1'b0;
            end
        end else begin
            unique case (state_q.st)
                ST_RX: if (scl_rise) begin
                    state_d.sh  = byte_in;
                    state_d.cnt = state_q.cnt + 3'd1;
                    if (state_q.cnt == 3'd7) begin
                        unique case (state_q.ph)
                            PH_DEVICE: begin
                                if (byte_in[7:1] == DEV_ADDR && state_q.busy == '0) begin
                                    state_d.rd = byte_in[0];
                                    state_d.st = ST_ACK_ARM;
                                end else begin
                                    state_d.st = ST_IDLE;
                                end
                            end
                            PH_WORD: begin
                                state_d.ptr = byte_in[ADDR_W-1:0];
                                state_d.st  = ST_ACK_ARM;
                            end
                            default: begin
                                // upper half only, and only while unprotected
                                bus_we        = state_q.ptr[ADDR_W-1] & ~wp_i;
                                state_d.ptr   = {state_q.ptr[ADDR_W-1:PAGE_W], page_nx};
                                state_d.wrote = 1'b1;
                                state_d.st    = ST_ACK_ARM;
                            end
                        endcase
                    end
                end
                ST_ACK_ARM: if (scl_fall) begin
                    state_d.oe = 1'b1;
                    state_d.o  = 1'b0;
                    state_d.st = ST_ACK;
                end
                ST_ACK: if (scl_fall) begin
                    state_d.cnt = 3'd0;
                    if (state_q.ph == PH_DEVICE && state_q.rd) begin
                        state_d.sh  = rdata;
                        state_d.o   = rdata[7];
                        state_d.oe  = 1'b1;
                        state_d.ptr = state_q.ptr + PTR_ONE;
                        state_d.st  = ST_TX;
                    end else begin
                        state_d.oe = 1'b0;
                        state_d.st = ST_RX;
                        state_d.ph = (state_q.ph == PH_DEVICE) ? PH_WORD : PH_DATA;
                    end
                end
                ST_TX: if (scl_fall) begin
                    if (state_q.cnt == 3'd7) begin
                        state_d.oe = 1'b0;
                        state_d.st = ST_MACK;
                    end else begin
                        state_d.sh  = {state_q.sh[6:0], 1'b0};
                        state_d.o   = state_q.sh[6];
                        state_d.cnt = state_q.cnt + 3'd1;
                    end
                end
                ST_MACK: if (scl_rise) begin
                    state_d.st = sda_s ? ST_IDLE : ST_TX_NEXT;
                end
                ST_TX_NEXT: if (scl_fall) begin
                    state_d.sh  = rdata;
                    state_d.o   = rdata[7];
                    state_d.oe  = 1'b1;
                    state_d.cnt = 3'd0;
                    state_d.ptr = state_q.ptr + PTR_ONE;
                    state_d.st  = ST_TX;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.st    <= ST_IDLE;
            state_q.ph    <= PH_DEVICE;
            state_q.cnt   <= 3'd0;
            state_q.sh    <= 8'h00;
            state_q.ptr   <= '0;
            state_q.rd    <= 1'b0;
            state_q.oe    <= 1'b0;
            state_q.o     <= 1'b1;
            state_q.wrote <= 1'b0;
            state_q.busy  <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sda_o  = state_q.o;
    assign sda_oe = state_q.oe;
endmodule

// File: rtl/spd_eeprom_chk.sv
module spd_eeprom_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_i,
    input logic          wp_i,
    input logic          sda_o,
    input logic          sda_oe,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr
);
    AST_RESET_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !sda_oe); // R1

    AST_LOWER_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> bus_addr[AW-1]); // R5

    AST_WP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> !wp_i); // R7

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !$past(scl_i)); // R11

    AST_DATA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe && !$stable(sda_o)) |-> !$past(scl_i)); // R11
endmodule

bind spd_eeprom spd_eeprom_chk #(.AW(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .wp_i     (wp_i),
    .sda_o    (sda_o),
    .sda_oe   (sda_oe),
    .bus_we   (bus_we),
    .bus_addr (ptr_q)
);

// File: tb/spd_eeprom_tb.sv
module spd_eeprom_tb;
    localparam logic [6:0] DEV  = 7'h50;
    localparam int         BUSY = 1000;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       wp = 1'b0;
    logic       pre_en = 1'b0;
    logic [7:0] pre_addr = 8'h00;
    logic [7:0] pre_data = 8'h00;
    logic       sda_o, sda_oe;
    wire        bus_sda;

    assign bus_sda = sda_m & (sda_oe ? sda_o : 1'b1);

    spd_eeprom #(.DEV_ADDR(DEV), .BUSY_CYCLES(BUSY)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (bus_sda),
        .sda_o      (sda_o),
        .sda_oe     (sda_oe),
        .wp_i       (wp),
        .pre_en_i   (pre_en),
        .pre_addr_i (pre_addr),
        .pre_data_i (pre_data)
    );

    int tests = 0;
    int fails = 0;
    logic [7:0] mdl [256];

    typedef struct {
        string      tag;
        logic [7:0] val;
    } exp_t;
    exp_t       expq[$];
    logic [7:0] obs_v;
    event       obs_ev;

    // scoreboard monitor
    initial begin
        forever begin
            @(obs_ev);
            tests++;
            if (expq.size() == 0) begin
                fails++;
                $display("FAIL unexpected item: actual %h expected none", obs_v);
            end else begin
                exp_t e;
                e = expq.pop_front();
                if (obs_v !== e.val) begin
                    fails++;
                    $display("FAIL %s: actual %h expected %h", e.tag, obs_v, e.val);
                end
            end
        end
    end

    // R11: slave output may change only while SCL is low
    int r11_bad = 0;
    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && sda_oe !== oe_prev && scl_m) r11_bad++;
        oe_prev = sda_oe;
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic qw();
        repeat (4) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; qw();
        scl_m = 1'b1; qw();
        sda_m = 1'b0; qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; qw();
        scl_m = 1'b1; qw();
        sda_m = 1'b1; qw(); qw();
    endtask

    // ack expected: 8'h00 = ACK, 8'h01 = NACK
    task automatic send_byte(input logic [7:0] b, input logic [7:0] exp_ack, input string tag);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; qw();
            scl_m = 1'b1; qw(); qw();
            scl_m = 1'b0; qw();
        end
        sda_m = 1'b1; qw();
        scl_m = 1'b1; qw();
        expq.push_back('{tag, exp_ack});
        obs_v = {7'd0, bus_sda};
        ->obs_ev;
        qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic recv_byte(input logic [7:0] exp, input bit mack, input string tag);
        logic [7:0] r;
        r = 8'h00;
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            qw();
            scl_m = 1'b1; qw();
            r = {r[6:0], bus_sda};
            qw();
            scl_m = 1'b0;
        end
        expq.push_back('{tag, exp});
        obs_v = r;
        ->obs_ev;
        qw();
        sda_m = mack ? 1'b0 : 1'b1; qw();
        scl_m = 1'b1; qw(); qw();
        scl_m = 1'b0; qw();
        sda_m = 1'b1;
    endtask

    task automatic set_ptr(input logic [7:0] a, input string tag);
        i2c_start();
        send_byte({DEV, 1'b0}, 8'h00, tag);
        send_byte(a, 8'h00, tag);
    endtask

    task automatic rd_seq(input logic [7:0] a, input int n, input string tag);
        set_ptr(a, tag);
        i2c_start();
        send_byte({DEV, 1'b1}, 8'h00, tag);
        for (int k = 0; k < n; k++)
            recv_byte(mdl[8'(int'(a) + k)], k < n - 1, tag);
        i2c_stop();
    endtask

    task automatic wr_seq(input logic [7:0] a, input logic [7:0] d0, input int n, input string tag);
        logic [7:0] p;
        p = a;
        set_ptr(a, tag);
        for (int k = 0; k < n; k++) begin
            logic [7:0] d;
            d = d0 + 8'(k);
            send_byte(d, 8'h00, tag);
            if (p[7] && !wp) mdl[p] = d;
            p = {p[7:4], p[3:0] + 4'd1};
        end
        i2c_stop();
        repeat (BUSY + 100) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk("R1 oe in reset", {7'd0, sda_oe}, 8'h00);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 oe after reset", {7'd0, sda_oe}, 8'h00);

        // R10: preload pattern
        for (int i = 0; i < 256; i++) begin
            pre_en = 1'b1; pre_addr = 8'(i); pre_data = 8'(i) ^ 8'h5A;
            mdl[i] = 8'(i) ^ 8'h5A;
            @(negedge clk);
        end
        pre_en = 1'b0;
        rd_seq(8'h00, 2, "R10");
        rd_seq(8'h10, 1, "R3");
        rd_seq(8'h37, 1, "R3");
        rd_seq(8'hFE, 4, "R4");
        chk("R4 released after nack", {7'd0, sda_oe}, 8'h00);

        // R2: foreign device address refused
        i2c_start();
        send_byte({7'h51, 1'b0}, 8'h01, "R2");
        i2c_stop();
        i2c_start();
        send_byte({7'h50 ^ 7'h08, 1'b1}, 8'h01, "R2");
        i2c_stop();

        // R5: lower half locked
        wr_seq(8'h20, 8'hC3, 3, "R5");
        rd_seq(8'h20, 3, "R5");

        // R6: upper half writable; R9 busy window
        set_ptr(8'h80, "R6");
        send_byte(8'hA1, 8'h00, "R6");
        send_byte(8'hA2, 8'h00, "R6");
        mdl[8'h80] = 8'hA1; mdl[8'h81] = 8'hA2;
        i2c_stop();
        i2c_start();
        send_byte({DEV, 1'b0}, 8'h01, "R9");
        i2c_stop();
        repeat (BUSY + 100) @(negedge clk);
        i2c_start();
        send_byte({DEV, 1'b0}, 8'h00, "R9");
        i2c_stop();
        rd_seq(8'h80, 2, "R6");

        // R7: write protect holds the upper half
        wp = 1'b1;
        wr_seq(8'hC0, 8'h11, 2, "R7");
        wp = 1'b0;
        rd_seq(8'hC0, 2, "R7");

        // R8: page wrap inside a 16-byte page
        wr_seq(8'h9E, 8'hE0, 4, "R8");
        rd_seq(8'h90, 16, "R8");

        chk("R11 oe changes while scl high", 8'(r11_bad), 8'h00);

        repeat (20) @(negedge clk);
        if (expq.size() != 0) begin
            tests++; fails++;
            $display("FAIL scoreboard: actual %0d pending expected 0", expq.size());
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule